// File: doc/BRIEF.md
# Legacy IDE I/O Access Trap

This block snoops legacy I/O cycles issued on the host side and raises a system-management interrupt when an access hits one of the two fixed legacy disk channel address windows. A hit counts only when the trap enable for that channel and for the drive currently selected on it is set. Four enable bits cover the four channel/drive pairs. They are held in an 8-bit control register whose upper nibble is reserved.

On the first qualifying access, the block captures a record of the event and pulls the active-low interrupt line low. The record holds the channel, the drive, the full I/O address and the direction. Both the record and the interrupt hold until software pulses the write-1-to-clear strobe. A function-level reset drops any pending trap but leaves the enables alone. Only the main reset clears the enables.

Top module: `ide_io_trap`

## Requirements
- R1: After main reset, `cfg_rdata_o` is 00h, `smi_no` is 1 and `trap_valid_o` is 0.
- R2: A write through `cfg_we_i` stores bits 3:0 of `cfg_wdata_i`. Bits 7:4 always read 0. The new enables first apply to accesses sampled on the cycle after the write.
- R3: The primary window is addresses 01F0h to 01F7h plus 03F6h. Enable bit 0 traps primary hits while `pri_dev_i` is 0. Enable bit 1 traps them while `pri_dev_i` is 1.
- R4: The secondary window is addresses 0170h to 0177h plus 0376h. Enable bit 2 traps secondary hits while `sec_dev_i` is 0. Enable bit 3 traps them while `sec_dev_i` is 1.
- R5: A window hit does not trap when the enable bit for the channel's currently selected drive is clear, even if the other drive's bit on that channel is set.
- R6: An access outside both windows never traps, including the addresses next to each window and addresses whose upper bits differ.
- R7: `smi_no` goes low in the cycle after a trapping access is sampled. It stays low until the trap is cleared.
- R8: The record reports `trap_chan_o` (0 = primary, 1 = secondary), `trap_dev_o`, `trap_addr_o` and `trap_write_o` (1 = write) of the first trapping access. Later trapping accesses leave the record unchanged while it is valid.
- R9: A `sts_clr_i` pulse clears the record and releases `smi_no`. If a trapping access arrives in the same cycle as the clear, that access is captured as the new record.
- R10: `flr_i` clears the record and releases `smi_no`, and leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Main asynchronous reset, active low |
| flr_i | input | 1 | Function-level reset pulse |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register read value |
| io_valid_i | input | 1 | I/O cycle present this clock |
| io_addr_i | input | 16 | I/O address |
| io_write_i | input | 1 | 1 = write, 0 = read |
| pri_dev_i | input | 1 | Selected drive on the primary channel |
| sec_dev_i | input | 1 | Selected drive on the secondary channel |
| sts_clr_i | input | 1 | Write-1-to-clear pulse for the trap record |
| smi_no | output | 1 | System-management interrupt, active low |
| trap_valid_o | output | 1 | Record holds a trapped access |
| trap_chan_o | output | 1 | Channel of the trapped access |
| trap_dev_o | output | 1 | Selected drive at the trapped access |
| trap_addr_o | output | 16 | Address of the trapped access |
| trap_write_o | output | 1 | Direction of the trapped access |

## Verification
The main trap path is tested with several kinds of access:
- Each enable bit is tried alone, against window accesses with the drive select set both ways. This shows that every bit is tied to exactly one channel/drive pair.
- Window end points and the single alternate-status address are set against their immediate neighbours and an alias with upper address bits set. This separates a full 16-bit decode from a partial one.
- Sequences with back-to-back traps, clear pulses that coincide with new hits, and function-level resets show whether the record is sticky, whether the clear takes priority, and which reset touches which state.

// File: rtl/ide_trap_pkg.sv
package ide_trap_pkg;
  localparam int IO_ADDR_W = 16;
  localparam int NUM_CHAN  = 2;
  localparam int NUM_DEV   = 2;
  localparam int EN_W      = NUM_CHAN * NUM_DEV;
  localparam int CFG_W     = 8;
  localparam int WIN_LSB   = 3;

  localparam logic [IO_ADDR_W-1:0] PRI_BASE = 16'h01F0;
  localparam logic [IO_ADDR_W-1:0] PRI_ALT  = 16'h03F6;
  localparam logic [IO_ADDR_W-1:0] SEC_BASE = 16'h0170;
  localparam logic [IO_ADDR_W-1:0] SEC_ALT  = 16'h0376;

  typedef struct packed {
    logic                 chan;
    logic                 dev;
    logic [IO_ADDR_W-1:0] addr;
    logic                 write;
  } trap_rec_t;
endpackage

// File: rtl/ide_trap_decode.sv
module ide_trap_decode #(
  parameter int                ADDR_W   = 16,
  parameter int                WIN_BITS = 3,
  parameter logic [ADDR_W-1:0] BASE     = '0,
  parameter logic [ADDR_W-1:0] ALT      = '0
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] WIN_TOP = BASE + ADDR_W'((1 << WIN_BITS) - 1);

  logic blk_hit, alt_hit;
  assign blk_hit = (addr_i[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
  assign alt_hit = (addr_i == ALT);
  assign hit_o   = valid_i & (blk_hit | alt_hit);

  // R3 / R4: a hit only ever lies inside the window range or on the alternate address
  always_comb begin
    a_r6_hit_in_window: assert (!hit_o || (addr_i >= BASE && addr_i <= WIN_TOP) || addr_i == ALT);
  end
endmodule

// File: rtl/ide_trap_ctrl.sv
module ide_trap_ctrl
  import ide_trap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flr_i,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic [EN_W-1:0]  en_o
);
  logic [EN_W-1:0] en_q;

  // function-level reset intentionally absent here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i[EN_W-1:0];
  end

  assign en_o    = en_q;
  assign rdata_o = {{(CFG_W-EN_W){1'b0}}, en_q};

  a_r10_flr_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flr_i && !we_i) |=> $stable(rdata_o));
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[EN_W-1:0] == $past(wdata_i[EN_W-1:0])));
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[CFG_W-1:EN_W] == '0);
endmodule

// File: rtl/ide_trap_status.sv
module ide_trap_status
  import ide_trap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      flr_i,
  input  logic      clr_i,
  input  logic      hit_i,
  input  trap_rec_t rec_i,
  output logic      valid_o,
  output trap_rec_t rec_o
);
  logic      valid_q;
  trap_rec_t rec_q;
  logic      take;

  // a hit coinciding with a clear is captured, not lost
  assign take = hit_i & (~valid_q | clr_i) & ~flr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rec_q   <= '0;
    end else if (flr_i) begin
      valid_q <= 1'b0;
    end else if (take) begin
      valid_q <= 1'b1;
      rec_q   <= rec_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign rec_o   = rec_q;

  a_r8_record_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !clr_i && !flr_i) |=> (valid_q && $stable(rec_q)));
  a_r9_clear_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !valid_q);
  a_r10_flr_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flr_i |=> !valid_q);
endmodule

// File: rtl/ide_io_trap.sv
module ide_io_trap
  import ide_trap_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flr_i,
  input  logic                 cfg_we_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  output logic [CFG_W-1:0]     cfg_rdata_o,
  input  logic                 io_valid_i,
  input  logic [IO_ADDR_W-1:0] io_addr_i,
  input  logic                 io_write_i,
  input  logic                 pri_dev_i,
  input  logic                 sec_dev_i,
  input  logic                 sts_clr_i,
  output logic                 smi_no,
  output logic                 trap_valid_o,
  output logic                 trap_chan_o,
  output logic                 trap_dev_o,
  output logic [IO_ADDR_W-1:0] trap_addr_o,
  output logic                 trap_write_o
);
  logic [EN_W-1:0]     en;
  logic [NUM_CHAN-1:0] win_hit;
  logic [NUM_CHAN-1:0] dev_sel;
  logic [NUM_CHAN-1:0] ch_match;
  logic                any_match;
  trap_rec_t           new_rec, cur_rec;

  assign dev_sel = {sec_dev_i, pri_dev_i};

  ide_trap_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flr_i   (flr_i),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .en_o    (en)
  );

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    ide_trap_decode #(
      .ADDR_W   (IO_ADDR_W),
      .WIN_BITS (WIN_LSB),
      .BASE     (ch == 0 ? PRI_BASE : SEC_BASE),
      .ALT      (ch == 0 ? PRI_ALT  : SEC_ALT)
    ) i_dec (
      .valid_i (io_valid_i),
      .addr_i  (io_addr_i),
      .hit_o   (win_hit[ch])
    );
    // enable index = channel * NUM_DEV + selected drive
    assign ch_match[ch] = win_hit[ch] & en[ch*NUM_DEV + int'(dev_sel[ch])];
  end

  assign any_match = |ch_match;

  always_comb begin
    new_rec       = '0;
    new_rec.addr  = io_addr_i;
    new_rec.write = io_write_i;
    for (int ch = NUM_CHAN - 1; ch >= 0; ch--) begin
      if (ch_match[ch]) begin
        new_rec.chan = ch[0];
        new_rec.dev  = dev_sel[ch];
      end
    end
  end

  ide_trap_status i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flr_i   (flr_i),
    .clr_i   (sts_clr_i),
    .hit_i   (any_match),
    .rec_i   (new_rec),
    .valid_o (trap_valid_o),
    .rec_o   (cur_rec)
  );

  assign smi_no       = ~trap_valid_o;
  assign trap_chan_o  = cur_rec.chan;
  assign trap_dev_o   = cur_rec.dev;
  assign trap_addr_o  = cur_rec.addr;
  assign trap_write_o = cur_rec.write;

  always_comb begin
    a_r4_windows_disjoint: assert ($countones(win_hit) <= 1);
  end

  a_r7_smi_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_match && !flr_i) |=> !smi_no);
  a_r6_no_hit_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_valid_o && !any_match) |=> !trap_valid_o);
  a_r5_disabled_pair_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit[0] && !en[int'(pri_dev_i)]) |-> !ch_match[0]);
endmodule

// File: tb/test_ide_io_trap.sv
`timescale 1ns/1ps
module test_ide_io_trap;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flr_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic        io_valid_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        io_write_i = 1'b0;
  logic        pri_dev_i = 1'b0;
  logic        sec_dev_i = 1'b0;
  logic        sts_clr_i = 1'b0;
  logic        smi_no, trap_valid_o, trap_chan_o, trap_dev_o, trap_write_o;
  logic [15:0] trap_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ide_io_trap i_ide_io_trap (.*);

  typedef struct packed {
    logic [3:0]  en;
    logic [15:0] addr;
    logic        wr;
    logic        pd;
    logic        sd;
    logic        exp;
    logic        ch;
    logic        dv;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{4'h1, 16'h01F0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    '{4'h1, 16'h01F7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'h1, 16'h03F6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    '{4'h1, 16'h01F0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{4'h2, 16'h01F3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R3
    '{4'h2, 16'h01F3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5
    '{4'h4, 16'h0170, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R4
    '{4'h4, 16'h0376, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R4
    '{4'h8, 16'h0177, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R4
    '{4'h8, 16'h0177, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{4'hF, 16'h01EF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'hF, 16'h01F8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'hF, 16'h03F7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'hF, 16'h03F5, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{4'hF, 16'h016F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'hF, 16'h0178, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'hF, 16'h0377, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'hF, 16'h11F0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'h0, 16'h01F0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
    '{4'h3, 16'h0170, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk_i); sts_clr_i = 1'b1;
    @(negedge clk_i); sts_clr_i = 1'b0;
  endtask

  // drives one access for one cycle; returns at the following negedge
  task automatic access(input logic [15:0] a, input logic w, input logic pd, input logic sd);
    @(negedge clk_i);
    io_valid_i = 1'b1; io_addr_i = a; io_write_i = w; pri_dev_i = pd; sec_dev_i = sd;
    @(negedge clk_i);
    io_valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    check("R1 cfg", 32'(cfg_rdata_o), 32'h00);
    check("R1 smi", 32'(smi_no), 32'h1);
    check("R1 valid", 32'(trap_valid_o), 32'h0);
    rst_ni = 1'b1;

    // R2 reserved bits
    cfg_write(8'hFF);
    check("R2 reserved", 32'(cfg_rdata_o), 32'h0F);
    cfg_write(8'hA5);
    check("R2 store", 32'(cfg_rdata_o), 32'h05);

    for (int i = 0; i < NV; i++) begin
      cfg_write({4'h0, VEC[i].en});
      clear();
      access(VEC[i].addr, VEC[i].wr, VEC[i].pd, VEC[i].sd);
      check($sformatf("R3-6 vec%0d valid", i), 32'(trap_valid_o), 32'(VEC[i].exp));
      check($sformatf("R7 vec%0d smi", i), 32'(smi_no), 32'(!VEC[i].exp));
      if (VEC[i].exp) begin
        check($sformatf("R8 vec%0d rec", i),
              {12'h0, trap_chan_o, trap_dev_o, trap_write_o, trap_addr_o},
              {12'h0, VEC[i].ch, VEC[i].dv, VEC[i].wr, VEC[i].addr});
      end
    end

    // R8 first record kept
    cfg_write(8'h0F);
    clear();
    access(16'h01F2, 1'b1, 1'b0, 1'b0);
    access(16'h0175, 1'b0, 1'b0, 1'b1);
    check("R8 sticky", {12'h0, trap_chan_o, trap_dev_o, trap_write_o, trap_addr_o},
          {12'h0, 1'b0, 1'b0, 1'b1, 16'h01F2});
    // R7 held through idle cycles
    repeat (5) @(negedge clk_i);
    check("R7 held", 32'(smi_no), 32'h0);
    // R9 plain clear
    clear();
    check("R9 clear valid", 32'(trap_valid_o), 32'h0);
    check("R9 clear smi", 32'(smi_no), 32'h1);
    // R9 clear coinciding with a hit captures it
    access(16'h01F1, 1'b0, 1'b1, 1'b0);
    @(negedge clk_i);
    sts_clr_i = 1'b1; io_valid_i = 1'b1; io_addr_i = 16'h0376; io_write_i = 1'b1; sec_dev_i = 1'b1;
    @(negedge clk_i);
    sts_clr_i = 1'b0; io_valid_i = 1'b0;
    check("R9 clear+hit valid", 32'(trap_valid_o), 32'h1);
    check("R9 clear+hit rec", {12'h0, trap_chan_o, trap_dev_o, trap_write_o, trap_addr_o},
          {12'h0, 1'b1, 1'b1, 1'b1, 16'h0376});
    // R10 flr drops trap, keeps cfg
    @(negedge clk_i); flr_i = 1'b1;
    @(negedge clk_i); flr_i = 1'b0;
    check("R10 flr valid", 32'(trap_valid_o), 32'h0);
    check("R10 flr smi", 32'(smi_no), 32'h1);
    check("R10 flr cfg", 32'(cfg_rdata_o), 32'h0F);
    // R2 new enables not used in the write cycle
    cfg_write(8'h00);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 8'h01;
    io_valid_i = 1'b1; io_addr_i = 16'h01F0; pri_dev_i = 1'b0;
    @(negedge clk_i);
    cfg_we_i = 1'b0; io_valid_i = 1'b0;
    check("R2 write timing", 32'(trap_valid_o), 32'h0);
    access(16'h01F0, 1'b0, 1'b0, 1'b0);
    check("R2 applied next", 32'(trap_valid_o), 32'h1);
    // R1 main reset clears cfg
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 rereset cfg", 32'(cfg_rdata_o), 32'h00);
    check("R1 rereset valid", 32'(trap_valid_o), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule